// File: doc/BRIEF.md
# Triggered Buffer-to-Output Register Transfer

This block keeps a small file of word-wide staging buffers and one output word that drives an external pulse pattern. A trigger unit decides when a staged word is copied into the output word. The trigger is selected by a 3-bit method: a write to buffer 0, a timer underflow strobe, a position-detect strobe, both strobes (AND), either strobe (OR), or one-shot forms of the detect, AND and OR triggers.

The source buffer is named by a 4-bit pointer that sits in the upper bits of the output word itself. Each copied word therefore also carries the pointer to the next buffer. Software can chain a sequence of output patterns through the buffers, and the hardware then steps through it with no further writes. All registers are written through one word-wide port with byte enables. The only output is the current output word.

Top module: `pulse_xfer_ctrl`

## Requirements
- R1: After reset the output word is 0x0000, every buffer is 0x0000, the method is 0 (buffer-0 write) and the one-shot trigger is armed.
- R2: Write addresses 0 to 11 select buffers 0 to 11. wr_be[0] enables bits 7:0 and wr_be[1] enables bits 15:8. Address 12 is the output word. Address 13 is the method register, whose bits 2:0 are taken from wr_data[2:0] when wr_be[0] is set.
- R3: With method 0, every write to buffer 0 that has any byte enable set copies the merged new buffer-0 value into the output word on the same clock edge. The pointer bits are ignored, and writes to the other buffers trigger nothing.
- R4: Method 1 transfers on each timer underflow strobe, method 2 on each position-detect strobe and method 4 on either strobe. The output changes at the same clock edge that samples the strobe. In method 2 a timer underflow has no effect.
- R5: In methods 1 to 7 the source index is {out_word[15], out_word[14:12]}. The stored buffer value is copied as a whole word, so the new output names the next buffer and successive triggers walk a chain.
- R6: Method 3 latches each strobe as it arrives and transfers on the cycle in which both have been seen, counting strobes in that cycle. Both latches then clear. A write to the method register also clears them.
- R7: Methods 5, 6 and 7 act like methods 2, 3 and 4 but allow one transfer only. After it, further triggers are ignored until the method register or the output word is written.
- R8: A source index above 11 causes no transfer and leaves the output word unchanged. The trigger is still consumed.
- R9: A write to the output word takes effect only when both byte enables are set. A partial write is ignored.
- R10: When a full output-word write and a transfer fall in the same cycle, the written data wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-11 buffers, 12 output, 13 method) |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte enables, bit 0 for the low byte |
| tmr_uflow | input | 1 | Single-cycle timer underflow strobe |
| pos_det | input | 1 | Single-cycle position-detect strobe |
| out_word | output | 16 | Output word driving the pulse pattern |

## Verification
The assertions check several rules on every cycle. A full output write must land exactly one edge later, whatever trigger fires with it. A partial output write must not move the output. An invalid pointer must freeze the output. A one-shot trigger must disarm after firing and must then keep the output still. The chaining through several buffers, the AND latching across separate cycles, the re-arming of the one-shot modes, the merging of byte writes and the way buffer 0 ignores the pointer are shown only by the bench's scenarios. The bench compares these against its reference model.

// File: rtl/pxfer_pkg.sv
package pxfer_pkg;

   typedef enum logic [2:0] {
      M_BUF0WR    = 3'd0,
      M_UFLOW     = 3'd1,
      M_DETECT    = 3'd2,
      M_AND       = 3'd3,
      M_OR        = 3'd4,
      M_OS_DETECT = 3'd5,
      M_OS_AND    = 3'd6,
      M_OS_OR     = 3'd7
   } xfer_mode_e;

   function automatic logic mode_is_oneshot(xfer_mode_e m);
      return (m == M_OS_DETECT) || (m == M_OS_AND) || (m == M_OS_OR);
   endfunction

   function automatic logic mode_is_and(xfer_mode_e m);
      return (m == M_AND) || (m == M_OS_AND);
   endfunction

endpackage

// File: rtl/pxfer_bank.sv
module pxfer_bank #(
   parameter int DATA_W  = 16,
   parameter int NUM_BUF = 12,
   parameter int IDX_W   = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_BUF-1:0]    wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [DATA_W/8-1:0]   wr_be,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [DATA_W-1:0]     rd_word,
   output logic [DATA_W-1:0]     buf0_next
);

   localparam int BE_W = DATA_W / 8;

   logic [DATA_W-1:0] mem [NUM_BUF];
   logic [DATA_W-1:0] merged [NUM_BUF];

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      for (genvar y = 0; y < BE_W; y++) begin : g_byte
         assign merged[b][y*8 +: 8] = wr_be[y] ? wr_data[y*8 +: 8] : mem[b][y*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[b] <= '0;
         end else if (wr_sel[b]) begin
            mem[b] <= merged[b];
         end
      end
   end

   assign buf0_next = wr_sel[0] ? merged[0] : mem[0];

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (int'(rd_idx) == i) begin
            rd_word = mem[i];
         end
      end
   end

endmodule

// File: rtl/pxfer_trig.sv
module pxfer_trig
   import pxfer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  xfer_mode_e mode,
   input  logic       buf0_wr,
   input  logic       tmr_ev,
   input  logic       pos_ev,
   input  logic       mode_wr,
   input  logic       out_wr,
   output logic       fire,
   output logic       armed
);

   logic seen_t, seen_p;
   logic hit, oneshot, and_mode;

   assign oneshot  = mode_is_oneshot(mode);
   assign and_mode = mode_is_and(mode);

   always_comb begin
      unique case (mode)
         M_BUF0WR:               hit = buf0_wr;
         M_UFLOW:                hit = tmr_ev;
         M_DETECT, M_OS_DETECT:  hit = pos_ev;
         M_AND, M_OS_AND:        hit = (seen_t | tmr_ev) & (seen_p | pos_ev);
         M_OR, M_OS_OR:          hit = tmr_ev | pos_ev;
         default:                hit = 1'b0;
      endcase
   end

   assign fire = hit && (!oneshot || armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_t <= 1'b0;
         seen_p <= 1'b0;
      end else if (mode_wr || fire || !and_mode) begin
         seen_t <= 1'b0;
         seen_p <= 1'b0;
      end else begin
         seen_t <= seen_t | tmr_ev;
         seen_p <= seen_p | pos_ev;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
      end else if (mode_wr || out_wr) begin
         armed <= 1'b1;
      end else if (fire && oneshot) begin
         armed <= 1'b0;
      end
   end

endmodule

// File: rtl/pulse_xfer_ctrl.sv
module pulse_xfer_ctrl
   import pxfer_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_BUF = 12,
   parameter int PTR_LSB = 12,
   parameter int ADDR_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [DATA_W/8-1:0]  wr_be,
   input  logic                 tmr_uflow,
   input  logic                 pos_det,
   output logic [DATA_W-1:0]    out_word
);

   localparam int IDX_W     = $clog2(NUM_BUF);
   localparam int BE_W      = DATA_W / 8;
   localparam int OUT_ADDR  = NUM_BUF;
   localparam int MODE_ADDR = NUM_BUF + 1;

   if (DATA_W % 8 != 0) begin : g_chk_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (NUM_BUF < 2) begin : g_chk_buf
      $error("NUM_BUF must be at least 2");
   end
   if (PTR_LSB + IDX_W > DATA_W) begin : g_chk_ptr
      $error("pointer field does not fit in the data word");
   end
   if ((1 << ADDR_W) < NUM_BUF + 2) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_BUF-1:0] buf_sel;
   logic               cpu_out_wr, mode_wr, buf0_wr;
   xfer_mode_e         mode_q;
   logic [DATA_W-1:0]  out_q, rd_word, buf0_next, src_word;
   logic [IDX_W-1:0]   ptr, rd_idx;
   logic               idx_ok, fire, load, armed;

   always_comb begin
      for (int i = 0; i < NUM_BUF; i++) begin
         buf_sel[i] = wr_en && (int'(wr_addr) == i) && (|wr_be);
      end
   end

   assign cpu_out_wr = wr_en && (int'(wr_addr) == OUT_ADDR) && (&wr_be);
   assign mode_wr    = wr_en && (int'(wr_addr) == MODE_ADDR) && wr_be[0];
   assign buf0_wr    = buf_sel[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_BUF0WR;
      end else if (mode_wr) begin
         mode_q <= xfer_mode_e'(wr_data[2:0]);
      end
   end

   assign ptr    = out_q[PTR_LSB +: IDX_W];
   assign rd_idx = (mode_q == M_BUF0WR) ? '0 : ptr;
   assign idx_ok = int'(rd_idx) < NUM_BUF;

   pxfer_bank #(
      .DATA_W  (DATA_W),
      .NUM_BUF (NUM_BUF),
      .IDX_W   (IDX_W)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (buf_sel),
      .wr_data   (wr_data),
      .wr_be     (wr_be),
      .rd_idx    (rd_idx),
      .rd_word   (rd_word),
      .buf0_next (buf0_next)
   );

   pxfer_trig i_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .buf0_wr (buf0_wr),
      .tmr_ev  (tmr_uflow),
      .pos_ev  (pos_det),
      .mode_wr (mode_wr),
      .out_wr  (cpu_out_wr),
      .fire    (fire),
      .armed   (armed)
   );

   assign src_word = (mode_q == M_BUF0WR) ? buf0_next : rd_word;
   assign load     = fire && idx_ok && !cpu_out_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (cpu_out_wr) begin
         out_q <= wr_data;
      end else if (load) begin
         out_q <= src_word;
      end
   end

   assign out_word = out_q;

endmodule

// File: rtl/pxfer_chk.sv
module pxfer_chk #(
   parameter int DATA_W  = 16,
   parameter int NUM_BUF = 12,
   parameter int PTR_LSB = 12,
   parameter int ADDR_W  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [DATA_W/8-1:0] wr_be,
   input logic [DATA_W-1:0]   out_word,
   input logic [2:0]          mode,
   input logic                fire,
   input logic                armed
);

   localparam int IDX_W = $clog2(NUM_BUF);

   logic out_hit, full_wr, part_wr, mode_hit, os_mode, bad_idx;

   assign out_hit  = wr_en && (int'(wr_addr) == NUM_BUF);
   assign full_wr  = out_hit && (&wr_be);
   assign part_wr  = out_hit && !(&wr_be);
   assign mode_hit = wr_en && (int'(wr_addr) == NUM_BUF + 1) && wr_be[0];
   assign os_mode  = mode >= 3'd5;
   assign bad_idx  = (mode != 3'd0) && (int'(out_word[PTR_LSB +: IDX_W]) >= NUM_BUF);

   // R10: a full output write lands on the next edge, whatever else fires
   a_r10_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr |=> out_word == $past(wr_data));

   // R9: partial writes to the output word leave it untouched
   a_r9_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (part_wr && !fire) |=> $stable(out_word));

   // R8: a trigger with an out-of-range pointer moves nothing
   a_r8_bad_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && bad_idx && !full_wr) |=> $stable(out_word));

   // R7: a one-shot trigger disarms after it fires
   a_r7_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && os_mode && !mode_hit && !full_wr) |=> !armed);

   // R7: while disarmed the output holds
   a_r7_oneshot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && os_mode && !mode_hit && !full_wr) |=> $stable(out_word));

endmodule

bind pulse_xfer_ctrl pxfer_chk #(
   .DATA_W  (DATA_W),
   .NUM_BUF (NUM_BUF),
   .PTR_LSB (PTR_LSB),
   .ADDR_W  (ADDR_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .wr_be    (wr_be),
   .out_word (out_word),
   .mode     (mode_q),
   .fire     (fire),
   .armed    (armed)
);

// File: tb/test_pulse_xfer_ctrl.sv
module test_pulse_xfer_ctrl;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic        tmr_uflow = 1'b0;
   logic        pos_det = 1'b0;
   logic [15:0] out_word;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pulse_xfer_ctrl i_pulse_xfer_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .tmr_uflow(tmr_uflow),
      .pos_det(pos_det), .out_word(out_word)
   );

   // behavioural reference model
   int m_buf [12];
   int m_out, m_mode;
   bit m_st, m_sp, m_armed;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_buf[i]) m_buf[i] = 0;
         m_out = 0; m_mode = 0; m_st = 0; m_sp = 0; m_armed = 1;
      end else begin
         bit cpu_out, mwr, hit, fire, os, andm, st, sp;
         int nb0, idx, src, nxt;
         cpu_out = wr_en && wr_addr == 12 && wr_be == 2'b11;
         mwr     = wr_en && wr_addr == 13 && wr_be[0];
         nb0 = m_buf[0];
         if (wr_en && wr_addr == 0) begin
            if (wr_be[0]) nb0 = (nb0 & 'hFF00) | (wr_data & 'h00FF);
            if (wr_be[1]) nb0 = (nb0 & 'h00FF) | (wr_data & 'hFF00);
         end
         os   = m_mode >= 5;
         andm = (m_mode == 3) || (m_mode == 6);
         st = m_st || tmr_uflow;
         sp = m_sp || pos_det;
         case (m_mode)
            0: hit = wr_en && wr_addr == 0 && wr_be != 0;
            1: hit = tmr_uflow;
            2, 5: hit = pos_det;
            3, 6: hit = st && sp;
            default: hit = tmr_uflow || pos_det;
         endcase
         fire = hit && (!os || m_armed);
         idx  = (m_mode == 0) ? 0 : ((m_out >> 12) & 'hF);
         src  = (m_mode == 0) ? nb0 : ((idx < 12) ? m_buf[idx] : 0);
         nxt  = m_out;
         if (cpu_out) nxt = wr_data;
         else if (fire && idx < 12) nxt = src;
         if (wr_en && wr_addr < 12) begin
            int v;
            v = m_buf[wr_addr];
            if (wr_be[0]) v = (v & 'hFF00) | (wr_data & 'h00FF);
            if (wr_be[1]) v = (v & 'h00FF) | (wr_data & 'hFF00);
            m_buf[wr_addr] = v;
         end
         if (mwr || fire || !andm) begin m_st = 0; m_sp = 0; end
         else begin m_st = st; m_sp = sp; end
         if (mwr || cpu_out) m_armed = 1;
         else if (fire && os) m_armed = 0;
         if (mwr) m_mode = wr_data[2:0];
         m_out = nxt;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (out_word !== m_out[15:0]) begin
            failures++;
            $display("FAIL per-cycle model (any of R1 to R10 by scenario) act=%h exp=%h",
                     out_word, m_out[15:0]);
         end
      end
   end

   task automatic chk(string req, logic [15:0] exp);
      checks++;
      if (out_word !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, out_word, exp);
      end
   endtask

   task automatic cyc(bit we, int a, int d, int be, bit t, bit p);
      @(negedge clk);
      wr_en = we; wr_addr = a[3:0]; wr_data = d[15:0]; wr_be = be[1:0];
      tmr_uflow = t; pos_det = p;
      @(negedge clk);
      wr_en = 0; wr_be = 0; tmr_uflow = 0; pos_det = 0;
   endtask

   task automatic wr(int a, int d);
      cyc(1, a, d, 3, 0, 0);
   endtask

   initial begin
      #(CLK_P * 50000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset output", 16'h0000);
      // R3: buffer-0 write method, pointer ignored
      wr(12, 'h3000);           chk("R9 full output write", 16'h3000);
      wr(0, 'h5A5A);            chk("R3 buf0 write copies", 16'h5A5A);
      cyc(1, 0, 'hFFC3, 1, 0, 0); chk("R2 R3 low-byte buf0 merge", 16'h5AC3);
      wr(2, 'h5111);
      wr(5, 'h0222);            chk("R3 other buffers no trigger", 16'h5AC3);
      // R4/R5 timer underflow with chaining
      wr(13, 1);
      wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R4 underflow transfer", 16'h5111);
      cyc(0, 0, 0, 0, 1, 0);    chk("R5 chain to buffer 5", 16'h0222);
      cyc(0, 0, 0, 0, 1, 0);    chk("R5 chain to buffer 0", 16'h5AC3);
      // R4 detect only
      wr(13, 2); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R4 detect ignores underflow", 16'h2000);
      cyc(0, 0, 0, 0, 0, 1);    chk("R4 detect transfer", 16'h5111);
      // R6 AND
      wr(13, 3); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R6 AND waits", 16'h2000);
      cyc(0, 0, 0, 0, 0, 1);    chk("R6 AND both seen", 16'h5111);
      cyc(0, 0, 0, 0, 0, 1);    chk("R6 latches cleared", 16'h5111);
      cyc(0, 0, 0, 0, 1, 1);    chk("R6 AND same cycle", 16'h0222);
      // R4 OR
      wr(13, 4); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 0, 1);    chk("R4 OR detect", 16'h5111);
      cyc(0, 0, 0, 0, 1, 0);    chk("R4 OR underflow", 16'h0222);
      // R7 one-shot
      wr(13, 5); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 0, 1);    chk("R7 one-shot first", 16'h5111);
      cyc(0, 0, 0, 0, 0, 1);    chk("R7 one-shot ignored", 16'h5111);
      wr(13, 5);
      cyc(0, 0, 0, 0, 0, 1);    chk("R7 rearm by method write", 16'h0222);
      wr(13, 6); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 1);    chk("R7 one-shot AND", 16'h5111);
      cyc(0, 0, 0, 0, 1, 1);    chk("R7 one-shot AND disarmed", 16'h5111);
      wr(13, 7); wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R7 one-shot OR", 16'h5111);
      cyc(0, 0, 0, 0, 1, 0);    chk("R7 one-shot OR disarmed", 16'h5111);
      wr(12, 'h2000);
      cyc(0, 0, 0, 0, 0, 1);    chk("R7 rearm by output write", 16'h5111);
      // R8 invalid index
      wr(13, 1); wr(12, 'hC000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R8 index 12 no transfer", 16'hC000);
      wr(12, 'hF123);
      cyc(0, 0, 0, 0, 1, 0);    chk("R8 index 15 no transfer", 16'hF123);
      // R9 partial writes
      cyc(1, 12, 'hABCD, 2, 0, 0); chk("R9 high-byte write ignored", 16'hF123);
      cyc(1, 12, 'hABCD, 1, 0, 0); chk("R9 low-byte write ignored", 16'hF123);
      // R10 priority
      wr(12, 'h2000);
      cyc(1, 12, 'h7777, 3, 1, 0); chk("R10 CPU write wins", 16'h7777);
      cyc(0, 0, 0, 0, 1, 0);    chk("R5 pointer 7 source", 16'h0000);
      // R2 high-byte buffer write then transfer
      cyc(1, 2, 'h9900, 2, 0, 0);
      wr(12, 'h2000);
      cyc(0, 0, 0, 0, 1, 0);    chk("R2 high-byte buffer merge", 16'h9911);
      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule